// File: doc/BRIEF.md
# Byte, Halfword and Bit Permutation Unit

This block rearranges a 64-bit register operand at one of several granularities. It can swap bytes inside halfwords, reverse byte order inside each word or across the whole doubleword, swap or reverse halfwords, reverse the bits inside each byte, and reverse all bits in word or doubleword form. A 4-bit select chooses the permutation. A valid strobe qualifies the operand and the select. The result comes out of a single register stage together with a valid flag.

Word-form permutations only use the low 32 bits of the operand. They replicate result bit 31 into bits 63:32. The doubleword forms write all 64 bits and do not extend. A select value with no permutation assigned to it produces an all-zero result and raises an illegal-operation flag. Instruction decode and register-file access belong to the surrounding pipeline.

Top module: `bitperm_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. The result of an accepted operation is visible one clock edge after acceptance.
- R3: Select 0 swaps the two bytes of each halfword in operand bits 31:0. Result bits 63:32 copy result bit 31.
- R4: Select 1 swaps the two bytes of each of the four halfwords of the 64-bit operand, with no extension.
- R5: Select 2 reverses byte order inside each 32-bit word and keeps each word in place. Select 3 reverses the order of all eight bytes.
- R6: Select 4 exchanges the two halfwords of each 32-bit word. Select 5 reverses the order of all four halfwords.
- R7: Select 6 reverses the bit order inside each byte of bits 31:0 and sign-extends from result bit 31. Select 7 reverses the bits inside all eight bytes, with no extension.
- R8: Select 8 reverses bits 31:0, so result bit i is operand bit 31-i, and sign-extends from result bit 31. Select 9 reverses all 64 bits.
- R9: Select values 10 to 15 give an all-zero result with `out_illegal` high. Selects 0 to 9 give `out_illegal` low.
- R10: A cycle with `in_valid` low leaves `out_result` and `out_illegal` unchanged, whatever `in_operand` and `in_sel` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and select are valid this cycle |
| in_sel | input | 4 | Permutation select (0 to 9 legal) |
| in_operand | input | 64 | Source operand |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Permuted result |
| out_illegal | output | 1 | Select of the accepted operation was unsupported |

## Verification
On every cycle, the assertions check the following:
- the one-cycle latency of the valid flag;
- the illegal flag and the zero result for unsupported selects;
- the upper-half replication for the three word forms;
- the preservation of the population count by the full byte reversal;
- the holding of the result while no operation is accepted.

The exact placement of each byte, halfword and bit for every select can only be shown by the bench's scenarios. The bench sweeps all sixteen select values over corner and pseudo-random operands and compares each result against a bit-index model.

// File: rtl/bitperm_pkg.sv
`timescale 1ns/1ps
package bitperm_pkg;

  typedef enum logic [3:0] {
    OP_BSWAP_H32  = 4'd0,
    OP_BSWAP_H64  = 4'd1,
    OP_BREV_WORDS = 4'd2,
    OP_BREV_DW    = 4'd3,
    OP_HSWAP_W    = 4'd4,
    OP_HREV_DW    = 4'd5,
    OP_BITREV_B32 = 4'd6,
    OP_BITREV_B64 = 4'd7,
    OP_BITREV_W   = 4'd8,
    OP_BITREV_DW  = 4'd9
  } bp_op_e;

  localparam logic [3:0] LAST_LEGAL_OP = 4'd9;

  function automatic logic op_is_word(input logic [3:0] s);
    return (s == OP_BSWAP_H32) || (s == OP_BITREV_B32) || (s == OP_BITREV_W);
  endfunction

  function automatic logic op_is_legal(input logic [3:0] s);
    return s <= LAST_LEGAL_OP;
  endfunction

endpackage

// File: rtl/bp_byte_net.sv
`timescale 1ns/1ps
// Byte and halfword granular permutations of the full operand.
module bp_byte_net #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] bswap_half,
  output logic [XLEN-1:0] brev_word,
  output logic [XLEN-1:0] brev_all,
  output logic [XLEN-1:0] hswap_word,
  output logic [XLEN-1:0] hrev_all
);
  localparam int NBYTE = XLEN / 8;
  localparam int NHALF = XLEN / 16;
  localparam int BPW   = 4;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign bswap_half[b*8 +: 8] = operand[(b ^ 1)*8 +: 8];
    assign brev_word[b*8 +: 8]  = operand[((b / BPW) * BPW + (BPW - 1 - (b % BPW)))*8 +: 8];
    assign brev_all[b*8 +: 8]   = operand[(NBYTE - 1 - b)*8 +: 8];
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign hswap_word[h*16 +: 16] = operand[(h ^ 1)*16 +: 16];
    assign hrev_all[h*16 +: 16]   = operand[(NHALF - 1 - h)*16 +: 16];
  end
endmodule

// File: rtl/bp_bit_net.sv
`timescale 1ns/1ps
// Bit granular reversals of the full operand.
module bp_bit_net #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] rev_in_byte,
  output logic [XLEN-1:0] rev_all
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign rev_in_byte[i] = operand[(i / 8) * 8 + (7 - (i % 8))];
    assign rev_all[i]     = operand[XLEN - 1 - i];
  end
endmodule

// File: rtl/bitperm_unit.sv
`timescale 1ns/1ps
module bitperm_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      in_sel,
  input  logic [XLEN-1:0] in_operand,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  import bitperm_pkg::*;

  localparam int WORD_W = 32;
  localparam int EXT_W  = XLEN - WORD_W;

  logic [XLEN-1:0] bswap_half, brev_word, brev_all, hswap_word, hrev_all;
  logic [XLEN-1:0] bit_in_byte, bit_all;
  logic [XLEN-1:0] perm_raw, result_d;
  logic            illegal_d;
  bp_op_e          op;

  assign op = bp_op_e'(in_sel);

  bp_byte_net #(.XLEN(XLEN)) u_byte_net (
    .operand    (in_operand),
    .bswap_half (bswap_half),
    .brev_word  (brev_word),
    .brev_all   (brev_all),
    .hswap_word (hswap_word),
    .hrev_all   (hrev_all)
  );

  bp_bit_net #(.XLEN(XLEN)) u_bit_net (
    .operand     (in_operand),
    .rev_in_byte (bit_in_byte),
    .rev_all     (bit_all)
  );

  // Next-state: select the permutation, then extend word forms.
  always_comb begin
    illegal_d = !op_is_legal(in_sel);
    case (op)
      OP_BSWAP_H32, OP_BSWAP_H64: perm_raw = bswap_half;
      OP_BREV_WORDS:              perm_raw = brev_word;
      OP_BREV_DW:                 perm_raw = brev_all;
      OP_HSWAP_W:                 perm_raw = hswap_word;
      OP_HREV_DW:                 perm_raw = hrev_all;
      OP_BITREV_B32,
      OP_BITREV_B64:              perm_raw = bit_in_byte;
      // Reversal of the low word lands in the upper word of the full reversal.
      OP_BITREV_W:                perm_raw = {{EXT_W{1'b0}}, bit_all[XLEN-1 -: WORD_W]};
      OP_BITREV_DW:               perm_raw = bit_all;
      default:                    perm_raw = '0;
    endcase
    if (op_is_word(in_sel)) begin
      result_d = {{EXT_W{perm_raw[WORD_W-1]}}, perm_raw[WORD_W-1:0]};
    end else begin
      result_d = perm_raw;
    end
  end

  // Registers: valid always tracks the strobe, data loads only when enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_valid) begin
      out_result  <= result_d;
      out_illegal <= illegal_d;
    end
  end
endmodule

// File: rtl/bitperm_unit_chk.sv
`timescale 1ns/1ps
module bitperm_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [3:0]      in_sel,
  input logic [XLEN-1:0] in_operand,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == 4'd0) |=> out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}});
  p_popcnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == 4'd3) |=> $countones(out_result) == $countones($past(in_operand)));
  p_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == 4'd6) |=> out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}});
  p_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == 4'd8) |=> out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}});
  p_bad_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel > 4'd9) |=> (out_illegal && out_result == '0));
  p_good_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel <= 4'd9) |=> !out_illegal);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal)));
endmodule

bind bitperm_unit bitperm_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sel      (in_sel),
  .in_operand  (in_operand),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/bitperm_unit_tb.sv
`timescale 1ns/1ps
module bitperm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_sel;
  logic [63:0] in_operand;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bitperm_unit #(.XLEN(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
    .in_operand(in_operand), .out_valid(out_valid), .out_result(out_result),
    .out_illegal(out_illegal)
  );

  function automatic logic [63:0] model(input int sel, input logic [63:0] x);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) begin
      int b = i / 8;
      int k = i % 8;
      int h = i / 16;
      int q = i % 16;
      case (sel)
        0: if (i < 32) r[i] = x[(b ^ 1) * 8 + k];
        1: r[i] = x[(b ^ 1) * 8 + k];
        2: r[i] = x[((b & 4) | (3 - (b & 3))) * 8 + k];
        3: r[i] = x[(7 - b) * 8 + k];
        4: r[i] = x[(h ^ 1) * 16 + q];
        5: r[i] = x[(3 - h) * 16 + q];
        6: if (i < 32) r[i] = x[b * 8 + 7 - k];
        7: r[i] = x[b * 8 + 7 - k];
        8: if (i < 32) r[i] = x[31 - i];
        9: r[i] = x[63 - i];
        default: r[i] = 1'b0;
      endcase
    end
    if (sel == 0 || sel == 6 || sel == 8) r[63:32] = {32{r[31]}};
    return r;
  endfunction

  function automatic string req_of(input int sel);
    case (sel)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5: return "R6";
      6, 7: return "R7";
      8, 9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input int sel, input logic [63:0] x);
    in_valid   = 1'b1;
    in_sel     = sel[3:0];
    in_operand = x;
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd1);
    check(req_of(sel), out_result, model(sel, x));
    check("R9", {63'd0, out_illegal}, {63'd0, (sel > 9)});
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] lfsr = 64'h0123_4567_89AB_CDEF;
    logic [63:0] corners [6];
    logic [63:0] keep_res;
    logic        keep_ill;
    corners[0] = 64'h0;
    corners[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[2] = 64'h8000_0000_0000_0000;
    corners[3] = 64'h0000_0000_8000_0000;
    corners[4] = 64'h0000_0000_0000_00FF;
    corners[5] = 64'h0123_4567_89AB_CDEF;
    rst_n = 1'b0; in_valid = 1'b0; in_sel = 4'd0; in_operand = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", {62'd0, out_valid, out_illegal}, 64'd0);
    check("R1", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 6; c++) run_op(s, corners[c]);
      for (int n = 0; n < 40; n++) begin
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        run_op(s, lfsr);
      end
    end
    // R10: idle cycles with changing inputs leave outputs alone
    for (int s = 0; s < 16; s++) begin
      run_op(s, 64'h0F1E_2D3C_4B5A_6978 ^ {60'd0, s[3:0]});
      keep_res = out_result;
      keep_ill = out_illegal;
      in_valid = 1'b0;
      in_sel = 4'(15 - s);
      in_operand = ~in_operand;
      @(negedge clk);
      check("R2", {63'd0, out_valid}, 64'd0);
      check("R10", out_result, keep_res);
      check("R10", {63'd0, out_illegal}, {63'd0, keep_ill});
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule